// File: doc/BRIEF.md
# Serial Link Status Flag Controller

This block keeps the four status flags of a byte-level controller for a variable-pulse-width serial vehicle bus. It also drives that controller's interrupt request. The flags are error, transmit-ready, receive-full and arbitration-lost. The block takes one-cycle event strobes from the transmit and receive state machines, and access strobes from the CPU or DMA. It turns them into flag updates, a queued-opcode cancel pulse and one interrupt line.

Transmit-ready tracks one queued transmit opcode. Each queued opcode is tagged as aimed at the current frame or at the next frame. When a bus event arrives, that tag decides whether the opcode is dropped, which raises transmit-ready and pulses the cancel output, or kept.

The status byte is laid out as follows: bit 7 is error, bit 6 is transmit-ready, bit 5 is receive-full, bit 4 is arbitration-lost, and bits 3..0 read zero. The mask bus uses this order: bit 3 is error, bit 2 is transmit-ready, bit 1 is receive-full, bit 0 is arbitration-lost.

Top module: `vpw_status_ctrl`

## Requirements
- R1: After reset, `status_byte` equals 0x40, with only transmit-ready set, and `irq` and `cancel` are 0.
- R2: If `ctl_disable` is 1 or `ctl_enable` is 0 during a cycle, `status_byte` is 0x40 at the next cycle, whatever other inputs are active.
- R3: The error flag is 1 in the cycle after any bit of `err_bits` is 1, and it returns to 0 in the cycle after all bits are 0.
- R4: A write to the opcode register without `opcode_abort` clears transmit-ready in the next cycle. `opcode_take` then sets it again.
- R5: A write to the opcode register with `opcode_abort` set leaves transmit-ready at 1.
- R6: If arbitration is lost while the pending opcode targets the current frame, transmit-ready rises. If the opcode targets the next frame (`opcode_next`=1 at write), transmit-ready stays 0.
- R7: A frame-class error (`ev_frame_err`: invalid bit, invalid frame or CRC error) raises transmit-ready for a current-frame opcode. It leaves a next-frame opcode pending.
- R8: A received break (`ev_rx_break`) drops any pending opcode, whichever frame it targets, and raises transmit-ready in the next cycle.
- R9: Receive-full sets in the cycle after `ev_byte_rx`, and clears in the cycle after `rxdata_rd` when no new byte arrives.
- R10: Arbitration-lost sets in the cycle after `ev_arb_lost`. It clears only when `stat_wr` occurs with `stat_wr_tla`=0. A status write with `stat_wr_tla`=1 leaves it set.
- R11: `irq` goes high two cycles after a flag rises while its mask bit is 1. It stays high until every masked flag is 0. A flag that rises while its mask bit is 0 leaves `irq` low.
- R12: `cancel` is a one-cycle pulse, issued together with the transmit-ready rise that drops a pending opcode (R6 to R8). It is never issued when `opcode_take` accepts the opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_enable | input | 1 | Block enable control bit |
| ctl_disable | input | 1 | Block disable control bit |
| irq_mask | input | 4 | Interrupt mask {err, trdy, rdrf, tla} |
| err_bits | input | ERR_W | Contents of the error register |
| opcode_wr | input | 1 | Write strobe to the transmit-opcode register |
| opcode_next | input | 1 | Written opcode targets the next frame |
| opcode_abort | input | 1 | Written opcode leads to a transmit abort |
| opcode_take | input | 1 | Transmit state machine accepts the opcode |
| ev_arb_lost | input | 1 | Arbitration lost strobe |
| ev_frame_err | input | 1 | Invalid bit, invalid frame or CRC error strobe |
| ev_rx_break | input | 1 | Received break strobe |
| ev_byte_rx | input | 1 | Complete byte moved to the receive-data register |
| rxdata_rd | input | 1 | Read strobe of the receive-data register |
| stat_wr | input | 1 | Write strobe to the status register |
| stat_wr_tla | input | 1 | Value written to the arbitration-lost bit |
| status_byte | output | 8 | Status byte |
| cancel | output | 1 | Pending opcode dropped (one-cycle pulse) |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that every event input is a single-cycle strobe. They also assume that `opcode_take`, `ev_arb_lost`, `ev_frame_err` and `ev_rx_break` never share a cycle with `opcode_wr`, because a write takes priority over them and would mask their effect. The directed tasks raise one strobe at a time on a falling edge and drop it on the next one. Between strobes they wait, so each flag change is seen separately before the next stimulus.

// File: rtl/vpw_status_pkg.sv
package vpw_status_pkg;

    localparam int NFLAG = 4;

    // flag vector order used for masks: {err, trdy, rdrf, tla}
    localparam int F_ERR  = 3;
    localparam int F_TRDY = 2;
    localparam int F_RDRF = 1;
    localparam int F_TLA  = 0;

    localparam logic [7:0] STATUS_RST = 8'h40;

    typedef struct packed {
        logic trdy;
        logic pend_next;
        logic cancel;
    } tx_state_t;

    typedef struct packed {
        logic err;
        logic rdrf;
        logic tla;
    } rx_state_t;

    typedef struct packed {
        logic [NFLAG-1:0] prev;
        logic             irq;
    } irq_state_t;

endpackage

// File: rtl/vpw_txrdy_sched.sv
module vpw_txrdy_sched
    import vpw_status_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic opcode_wr,
    input  logic opcode_next,
    input  logic opcode_abort,
    input  logic opcode_take,
    input  logic ev_arb_lost,
    input  logic ev_frame_err,
    input  logic ev_rx_break,
    output logic trdy,
    output logic cancel
);

    tx_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.cancel = 1'b0;
        if (!active) begin
            st_d.trdy      = 1'b1;
            st_d.pend_next = 1'b0;
        end else if (opcode_wr) begin
            if (opcode_abort) begin
                st_d.trdy      = 1'b1;
                st_d.pend_next = 1'b0;
            end else begin
                st_d.trdy      = 1'b0;
                st_d.pend_next = opcode_next;
            end
        end else if (!st_q.trdy) begin
            if (ev_rx_break) begin
                // a break drops every pending transmit, any frame
                st_d.trdy      = 1'b1;
                st_d.pend_next = 1'b0;
                st_d.cancel    = 1'b1;
            end else if ((ev_frame_err || ev_arb_lost) && !st_q.pend_next) begin
                st_d.trdy   = 1'b1;
                st_d.cancel = 1'b1;
            end else if (opcode_take) begin
                st_d.trdy      = 1'b1;
                st_d.pend_next = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{trdy: 1'b1, pend_next: 1'b0, cancel: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign trdy   = st_q.trdy;
    assign cancel = st_q.cancel;

    AST_WR_CLEARS_TRDY: assert property (@(posedge clk) disable iff (!rst_n)
        (active && opcode_wr && !opcode_abort) |=> !trdy); // R4

    AST_ABORT_KEEPS_TRDY: assert property (@(posedge clk) disable iff (!rst_n)
        (active && opcode_wr && opcode_abort) |=> trdy); // R5

    AST_BREAK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !opcode_wr && ev_rx_break) |=> trdy); // R8

    AST_CANCEL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cancel |-> (trdy && !$past(trdy))); // R12

    AST_CANCEL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cancel |=> !cancel); // R12

endmodule

// File: rtl/vpw_rx_flags.sv
module vpw_rx_flags
    import vpw_status_pkg::*;
#(
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [ERR_W-1:0] err_bits,
    input  logic             ev_byte_rx,
    input  logic             rxdata_rd,
    input  logic             ev_arb_lost,
    input  logic             stat_wr,
    input  logic             stat_wr_tla,
    output logic             err,
    output logic             rdrf,
    output logic             tla
);

    rx_state_t st_d, st_q;
    logic      tla_clr;

    assign tla_clr = stat_wr && !stat_wr_tla;

    always_comb begin
        st_d = st_q;
        if (!active) begin
            st_d = '0;
        end else begin
            st_d.err = |err_bits;
            if (ev_byte_rx) begin
                st_d.rdrf = 1'b1;
            end else if (rxdata_rd) begin
                st_d.rdrf = 1'b0;
            end
            if (ev_arb_lost) begin
                st_d.tla = 1'b1;
            end else if (tla_clr) begin
                st_d.tla = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign err  = st_q.err;
    assign rdrf = st_q.rdrf;
    assign tla  = st_q.tla;

    AST_ERR_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (active && (|err_bits)) |=> err); // R3

    AST_RDRF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (active && ev_byte_rx) |=> rdrf); // R9

    AST_TLA_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (active && tla && !tla_clr) |=> tla); // R10

endmodule

// File: rtl/vpw_irq_gen.sv
module vpw_irq_gen
    import vpw_status_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [NFLAG-1:0] flags,
    input  logic [NFLAG-1:0] mask,
    output logic             irq
);

    irq_state_t       st_d, st_q;
    logic [NFLAG-1:0] rise_m;
    logic [NFLAG-1:0] held_m;

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        assign rise_m[i] = flags[i] && !st_q.prev[i] && mask[i];
        assign held_m[i] = flags[i] && mask[i];
    end

    always_comb begin
        st_d.prev = flags;
        st_d.irq  = active && ((|rise_m) || (st_q.irq && (|held_m)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{prev: (NFLAG'(1) << F_TRDY), irq: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = st_q.irq;

    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(|flags)); // R11

endmodule

// File: rtl/vpw_status_ctrl.sv
module vpw_status_ctrl
    import vpw_status_pkg::*;
#(
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_enable,
    input  logic             ctl_disable,
    input  logic [3:0]       irq_mask,
    input  logic [ERR_W-1:0] err_bits,
    input  logic             opcode_wr,
    input  logic             opcode_next,
    input  logic             opcode_abort,
    input  logic             opcode_take,
    input  logic             ev_arb_lost,
    input  logic             ev_frame_err,
    input  logic             ev_rx_break,
    input  logic             ev_byte_rx,
    input  logic             rxdata_rd,
    input  logic             stat_wr,
    input  logic             stat_wr_tla,
    output logic [7:0]       status_byte,
    output logic             cancel,
    output logic             irq
);

    logic             active;
    logic             f_err, f_trdy, f_rdrf, f_tla;
    logic [NFLAG-1:0] flags;

    assign active = ctl_enable && !ctl_disable;

    vpw_txrdy_sched u_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .active       (active),
        .opcode_wr    (opcode_wr),
        .opcode_next  (opcode_next),
        .opcode_abort (opcode_abort),
        .opcode_take  (opcode_take),
        .ev_arb_lost  (ev_arb_lost),
        .ev_frame_err (ev_frame_err),
        .ev_rx_break  (ev_rx_break),
        .trdy         (f_trdy),
        .cancel       (cancel)
    );

    vpw_rx_flags #(.ERR_W(ERR_W)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .active      (active),
        .err_bits    (err_bits),
        .ev_byte_rx  (ev_byte_rx),
        .rxdata_rd   (rxdata_rd),
        .ev_arb_lost (ev_arb_lost),
        .stat_wr     (stat_wr),
        .stat_wr_tla (stat_wr_tla),
        .err         (f_err),
        .rdrf        (f_rdrf),
        .tla         (f_tla)
    );

    always_comb begin
        flags         = '0;
        flags[F_ERR]  = f_err;
        flags[F_TRDY] = f_trdy;
        flags[F_RDRF] = f_rdrf;
        flags[F_TLA]  = f_tla;
    end

    vpw_irq_gen u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (active),
        .flags  (flags),
        .mask   (irq_mask),
        .irq    (irq)
    );

    assign status_byte = {f_err, f_trdy, f_rdrf, f_tla, 4'b0000};

    AST_INACTIVE_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (status_byte == STATUS_RST)); // R2

    AST_LOW_NIBBLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        status_byte[3:0] == 4'b0000); // R1

endmodule

// File: tb/vpw_status_ctrl_tb_top.sv
`timescale 1ns/1ps
module vpw_status_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_enable = 1'b0, ctl_disable = 1'b0;
    logic [3:0] irq_mask = 4'h0;
    logic [7:0] err_bits = 8'h00;
    logic       opcode_wr = 0, opcode_next = 0, opcode_abort = 0, opcode_take = 0;
    logic       ev_arb_lost = 0, ev_frame_err = 0, ev_rx_break = 0, ev_byte_rx = 0;
    logic       rxdata_rd = 0, stat_wr = 0, stat_wr_tla = 0;
    logic [7:0] status_byte;
    logic       cancel, irq;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    vpw_status_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable), .ctl_disable(ctl_disable),
        .irq_mask(irq_mask), .err_bits(err_bits), .opcode_wr(opcode_wr),
        .opcode_next(opcode_next), .opcode_abort(opcode_abort), .opcode_take(opcode_take),
        .ev_arb_lost(ev_arb_lost), .ev_frame_err(ev_frame_err), .ev_rx_break(ev_rx_break),
        .ev_byte_rx(ev_byte_rx), .rxdata_rd(rxdata_rd), .stat_wr(stat_wr),
        .stat_wr_tla(stat_wr_tla), .status_byte(status_byte), .cancel(cancel), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // write an opcode: one-cycle strobe, result visible at return
    task automatic wr_op(input logic nxt, input logic abrt);
        opcode_wr = 1; opcode_next = nxt; opcode_abort = abrt;
        @(negedge clk);
        opcode_wr = 0; opcode_next = 0; opcode_abort = 0;
    endtask

    task automatic t_reset();
        chk("R1 status", status_byte, 8'h40);
        chk("R1 irq", {7'b0, irq}, 8'h00);
        chk("R1 cancel", {7'b0, cancel}, 8'h00);
    endtask

    task automatic t_inactive();
        ev_byte_rx = 1; ev_arb_lost = 1; err_bits = 8'h01;
        @(negedge clk);
        ev_byte_rx = 0; ev_arb_lost = 0;
        chk("R2 flags set first", status_byte, 8'hF0);
        ctl_disable = 1; ev_byte_rx = 1;
        @(negedge clk);
        ev_byte_rx = 0;
        chk("R2 disable forces", status_byte, 8'h40);
        ctl_disable = 0; ctl_enable = 0; err_bits = 8'h00;
        @(negedge clk);
        chk("R2 enable low holds", status_byte, 8'h40);
        ctl_enable = 1;
        idle(2);
    endtask

    task automatic t_err();
        err_bits = 8'h04;
        @(negedge clk);
        chk("R3 err set", status_byte & 8'h80, 8'h80);
        err_bits = 8'h84;
        @(negedge clk);
        chk("R3 err held", status_byte & 8'h80, 8'h80);
        err_bits = 8'h00;
        @(negedge clk);
        chk("R3 err auto clear", status_byte & 8'h80, 8'h00);
    endtask

    task automatic t_take();
        wr_op(0, 0);
        chk("R4 write clears trdy", status_byte & 8'h40, 8'h00);
        idle(2);
        chk("R4 trdy stays low", status_byte & 8'h40, 8'h00);
        opcode_take = 1;
        @(negedge clk);
        opcode_take = 0;
        chk("R4 take sets trdy", status_byte & 8'h40, 8'h40);
        chk("R12 no cancel on take", {7'b0, cancel}, 8'h00);
    endtask

    task automatic t_abort();
        wr_op(0, 1);
        chk("R5 abort keeps trdy", status_byte & 8'h40, 8'h40);
    endtask

    task automatic t_arb();
        wr_op(0, 0);
        ev_arb_lost = 1;
        @(negedge clk);
        ev_arb_lost = 0;
        chk("R6 current-frame trdy", status_byte & 8'h40, 8'h40);
        chk("R12 cancel on arb", {7'b0, cancel}, 8'h01);
        chk("R10 tla set", status_byte & 8'h10, 8'h10);
        @(negedge clk);
        chk("R12 cancel one cycle", {7'b0, cancel}, 8'h00);
        wr_op(1, 0);
        ev_arb_lost = 1;
        @(negedge clk);
        ev_arb_lost = 0;
        chk("R6 next-frame kept", status_byte & 8'h40, 8'h00);
        chk("R12 no cancel kept", {7'b0, cancel}, 8'h00);
        opcode_take = 1;
        @(negedge clk);
        opcode_take = 0;
    endtask

    task automatic t_frame_err();
        wr_op(0, 0);
        ev_frame_err = 1;
        @(negedge clk);
        ev_frame_err = 0;
        chk("R7 current-frame trdy", status_byte & 8'h40, 8'h40);
        chk("R7 cancel", {7'b0, cancel}, 8'h01);
        wr_op(1, 0);
        ev_frame_err = 1;
        @(negedge clk);
        ev_frame_err = 0;
        chk("R7 next-frame kept", status_byte & 8'h40, 8'h00);
    endtask

    task automatic t_break();
        // next-frame opcode from t_frame_err still pending
        ev_rx_break = 1;
        @(negedge clk);
        ev_rx_break = 0;
        chk("R8 break sets trdy", status_byte & 8'h40, 8'h40);
        chk("R8 break cancels", {7'b0, cancel}, 8'h01);
    endtask

    task automatic t_rdrf();
        ev_byte_rx = 1;
        @(negedge clk);
        ev_byte_rx = 0;
        chk("R9 rdrf set", status_byte & 8'h20, 8'h20);
        rxdata_rd = 1;
        @(negedge clk);
        rxdata_rd = 0;
        chk("R9 rdrf cleared", status_byte & 8'h20, 8'h00);
    endtask

    task automatic t_tla_clear();
        stat_wr = 1; stat_wr_tla = 1;
        @(negedge clk);
        stat_wr = 0; stat_wr_tla = 0;
        chk("R10 write one keeps", status_byte & 8'h10, 8'h10);
        stat_wr = 1;
        @(negedge clk);
        stat_wr = 0;
        chk("R10 write zero clears", status_byte & 8'h10, 8'h00);
    endtask

    task automatic t_irq();
        irq_mask = 4'b0010;
        ev_byte_rx = 1;
        @(negedge clk);
        ev_byte_rx = 0;
        @(negedge clk);
        chk("R11 irq on masked rise", {7'b0, irq}, 8'h01);
        idle(2);
        chk("R11 irq held", {7'b0, irq}, 8'h01);
        rxdata_rd = 1;
        @(negedge clk);
        rxdata_rd = 0;
        @(negedge clk);
        chk("R11 irq drops", {7'b0, irq}, 8'h00);
        ev_arb_lost = 1;
        @(negedge clk);
        ev_arb_lost = 0;
        idle(2);
        chk("R11 unmasked no irq", {7'b0, irq}, 8'h00);
        irq_mask = 4'b0000;
        stat_wr = 1;
        @(negedge clk);
        stat_wr = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        ctl_enable = 1;
        idle(2);
        t_reset();
        t_inactive();
        t_err();
        t_take();
        t_abort();
        t_arb();
        t_tla_clear();
        t_frame_err();
        t_break();
        t_rdrf();
        t_irq();
        idle(2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule